// File: doc/BRIEF.md
# Three-Level Hierarchical Interrupt Router

This block funnels a large set of interrupt sources onto three request lines towards a processor core: a critical line, a system-management line and a normal line. Peripheral sources compete in a peripheral encoder. The single winning peripheral is steered either to a high path, which feeds the critical line, or to a low path. The low path is merged into one slot of a main encoder. That encoder chooses one main source and raises either the management line or the normal line, depending on the top bit of that source's priority field. A small set of dedicated sources (external pin 0, timer slice 0 and wake-up logic) feeds a critical encoder directly and bypasses both other stages.

Each encoder latches its choice and holds it until the core pulses the clear input for the line that the choice drives. The latched index and the request line together tell the service routine which source fired. Because each encoder holds only one selection at a time, a pending normal or management request holds off a critical request that must pass through the peripheral encoder. The dedicated critical sources are not held off in this way.

Top module: `irq_router`

## Requirements
- R1: With the peripheral encoder idle and allowed to select, the requesting peripheral source with the numerically largest priority (bits [i*PW +: PW] of per_pri) is latched on the next rising edge and reported on per_idx with per_vld high. On equal priority the lowest source number wins.
- R2: A latched peripheral whose per_route_hi bit is 1 raises irq_crit on the following edge with crit_idx equal to NUM_DED (default 3), provided the critical encoder is idle.
- R3: A latched peripheral whose per_route_hi bit is 0 requests main slot MAIN_PER_SLOT (default 3). A peripheral is never on the high path and the low path at the same time.
- R4: With the main encoder idle, the requesting main source with the largest priority (bits [j*PW +: PW] of main_pri) is latched on the next edge, with ties going to the lowest index. External main requests fill the indices other than MAIN_PER_SLOT in ascending order.
- R5: A latched main source raises irq_mgmt when the top bit of its priority field was 1 at selection, and otherwise raises irq_norm. Its index appears on mgmt_idx or on norm_idx.
- R6: Only one main source is latched at a time. While irq_norm is high, irq_mgmt stays low even if a management-routed main source is requesting.
- R7: The peripheral encoder selects nothing while a main selection is latched. A critical request that passes through it therefore waits until the pending normal or management request is cleared.
- R8: A dedicated request reaches irq_crit on the next edge whenever the critical encoder is idle, whatever the main encoder is doing. The lowest dedicated index wins, and the peripheral high path ranks below all dedicated sources.
- R9: A latched selection holds its line and its index until the matching clear is pulsed. A dropped source request or a clear for a different line changes nothing. The encoder re-arbitrates on the edge after the clear.
- R10: Synchronous active-high rst clears every latched selection, so all request lines and valid bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| per_req | input | NUM_PER | Peripheral request levels |
| per_pri | input | NUM_PER*PW | Peripheral priority fields, source i at [i*PW +: PW] |
| per_route_hi | input | NUM_PER | 1 steers source to critical path, 0 to low path |
| main_req | input | NUM_MAIN-1 | External main request levels (slots other than the peripheral slot) |
| main_pri | input | NUM_MAIN*PW | Main priority fields; top bit selects management line |
| ded_req | input | NUM_DED | Dedicated critical request levels |
| clr_crit | input | 1 | Clear pulse for the critical line |
| clr_mgmt | input | 1 | Clear pulse for the management line |
| clr_norm | input | 1 | Clear pulse for the normal line |
| irq_crit | output | 1 | Critical request; also valid bit of crit_idx |
| crit_idx | output | $clog2(NUM_DED+1) | Critical cause; NUM_DED means peripheral high path |
| irq_mgmt | output | 1 | Management request; also valid bit of mgmt_idx |
| mgmt_idx | output | $clog2(NUM_MAIN) | Main slot behind irq_mgmt |
| irq_norm | output | 1 | Normal request; also valid bit of norm_idx |
| norm_idx | output | $clog2(NUM_MAIN) | Main slot behind irq_norm |
| per_vld | output | 1 | A peripheral selection is latched |
| per_idx | output | $clog2(NUM_PER) | Latched peripheral source number |

## Verification
The assertions assume that clear pulses come from a core that services what it sees. Clears may arrive at any time, but the hold checks only claim stability in cycles without a matching clear. Request levels may change at any cycle. The stimulus changes inputs only on the falling clock edge, holds every clear high for exactly one rising edge, and changes priorities only while all stages are idle. Before each scenario a drain sequence drops all requests and pulses every clear, so every scenario starts from empty encoders.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic {
        PATH_LOW  = 1'b0,
        PATH_HIGH = 1'b1
    } path_e;

    typedef enum logic {
        LINE_NORM = 1'b0,
        LINE_MGMT = 1'b1
    } line_e;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N  = 8,
    parameter int PW = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] pri,
    output logic            found,
    output logic [IW-1:0]   idx
);

    logic [PW-1:0] best;

    // Strictly-greater compare keeps the lowest index on ties.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || (pri[i*PW +: PW] > best))) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = pri[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/irq_per_stage.sv
module irq_per_stage
    import irq_router_pkg::*;
#(
    parameter int NP = 8,
    parameter int PW = 4,
    parameter int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP-1:0]    req,
    input  logic [NP*PW-1:0] pri,
    input  logic [NP-1:0]    route_hi,
    input  logic             allow,
    input  logic             clr,
    output logic             vld,
    output logic [IW-1:0]    idx,
    output path_e            path
);

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] idx;
        path_e         path;
    } per_st_t;

    per_st_t       st_d, st_q;
    logic          win_found;
    logic [IW-1:0] win_idx;

    irq_pick #(.N(NP), .PW(PW), .IW(IW)) pick_i (
        .req   (req),
        .pri   (pri),
        .found (win_found),
        .idx   (win_idx)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.vld) begin
            if (clr) begin
                st_d.vld = 1'b0;
            end
        end else if (allow && win_found) begin
            st_d.vld  = 1'b1;
            st_d.idx  = win_idx;
            st_d.path = route_hi[win_idx] ? PATH_HIGH : PATH_LOW;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld  = st_q.vld;
    assign idx  = st_q.idx;
    assign path = st_q.path;

    AST_PER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q.vld && !clr) |=> (st_q.vld && $stable(st_q.idx) && $stable(st_q.path))); // R9

    AST_PER_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.vld) |-> $past(allow)); // R7

endmodule

// File: rtl/irq_main_stage.sv
module irq_main_stage
    import irq_router_pkg::*;
#(
    parameter int NM = 4,
    parameter int PW = 4,
    parameter int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NM-1:0]    req,
    input  logic [NM*PW-1:0] pri,
    input  logic             clr_mgmt,
    input  logic             clr_norm,
    output logic             vld,
    output logic [IW-1:0]    idx,
    output line_e            line,
    output logic             clr_hit
);

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] idx;
        line_e         line;
    } main_st_t;

    main_st_t      st_d, st_q;
    logic          win_found;
    logic [IW-1:0] win_idx;
    logic [NM-1:0] msb_vec;

    genvar g;
    generate
        for (g = 0; g < NM; g++) begin : g_msb
            assign msb_vec[g] = pri[g*PW + PW - 1];
        end
    endgenerate

    irq_pick #(.N(NM), .PW(PW), .IW(IW)) pick_i (
        .req   (req),
        .pri   (pri),
        .found (win_found),
        .idx   (win_idx)
    );

    assign clr_hit = st_q.vld && ((st_q.line == LINE_MGMT) ? clr_mgmt : clr_norm);

    always_comb begin
        st_d = st_q;
        if (st_q.vld) begin
            if (clr_hit) begin
                st_d.vld = 1'b0;
            end
        end else if (win_found) begin
            st_d.vld  = 1'b1;
            st_d.idx  = win_idx;
            st_d.line = msb_vec[win_idx] ? LINE_MGMT : LINE_NORM;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld  = st_q.vld;
    assign idx  = st_q.idx;
    assign line = st_q.line;

    AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q.vld && !clr_hit) |=> (st_q.vld && $stable(st_q.idx) && $stable(st_q.line))); // R9

    AST_MGMT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (st_q.vld && (st_q.line == LINE_NORM) && !clr_norm) |=> !(st_q.vld && (st_q.line == LINE_MGMT))); // R6

endmodule

// File: rtl/irq_crit_stage.sv
module irq_crit_stage #(
    parameter int ND = 3,
    parameter int IW = $clog2(ND + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [ND-1:0] ded_req,
    input  logic          per_hi_req,
    input  logic          clr,
    output logic          vld,
    output logic [IW-1:0] idx
);

    localparam int NC = ND + 1;

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] idx;
    } crit_st_t;

    crit_st_t      st_d, st_q;
    logic [NC-1:0] cand;
    logic          win_found;
    logic [IW-1:0] win_idx;

    // Peripheral high path sits above all dedicated slots, so it loses ties.
    assign cand = {per_hi_req, ded_req};

    irq_pick #(.N(NC), .PW(1), .IW(IW)) pick_i (
        .req   (cand),
        .pri   ({NC{1'b0}}),
        .found (win_found),
        .idx   (win_idx)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.vld) begin
            if (clr) begin
                st_d.vld = 1'b0;
            end
        end else if (win_found) begin
            st_d.vld = 1'b1;
            st_d.idx = win_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld = st_q.vld;
    assign idx = st_q.idx;

    AST_DED_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!st_q.vld && (|ded_req)) |=> (st_q.vld && (st_q.idx != IW'(ND)))); // R8

    AST_CRIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q.vld && !clr) |=> (st_q.vld && $stable(st_q.idx))); // R9

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_PER       = 8,
    parameter int NUM_MAIN      = 4,
    parameter int MAIN_PER_SLOT = 3,
    parameter int NUM_DED       = 3,
    parameter int PW            = 4,
    localparam int PIW = (NUM_PER > 1) ? $clog2(NUM_PER) : 1,
    localparam int MIW = (NUM_MAIN > 1) ? $clog2(NUM_MAIN) : 1,
    localparam int CIW = $clog2(NUM_DED + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_PER-1:0]      per_req,
    input  logic [NUM_PER*PW-1:0]   per_pri,
    input  logic [NUM_PER-1:0]      per_route_hi,
    input  logic [NUM_MAIN-2:0]     main_req,
    input  logic [NUM_MAIN*PW-1:0]  main_pri,
    input  logic [NUM_DED-1:0]      ded_req,
    input  logic                    clr_crit,
    input  logic                    clr_mgmt,
    input  logic                    clr_norm,
    output logic                    irq_crit,
    output logic [CIW-1:0]          crit_idx,
    output logic                    irq_mgmt,
    output logic [MIW-1:0]          mgmt_idx,
    output logic                    irq_norm,
    output logic [MIW-1:0]          norm_idx,
    output logic                    per_vld,
    output logic [PIW-1:0]          per_idx
);

    path_e              per_path;
    logic               per_clr;
    logic               per_low_req;
    logic               per_hi_req;
    logic [NUM_MAIN-1:0] main_all_req;
    logic               main_vld;
    logic [MIW-1:0]     main_idx;
    line_e              main_line;
    logic               main_clr_hit;
    logic               crit_vld;
    logic [CIW-1:0]     crit_q_idx;

    // Merge the low path into its main slot; external requests fill the rest.
    genvar g;
    generate
        for (g = 0; g < NUM_MAIN; g++) begin : g_main_map
            if (g < MAIN_PER_SLOT) begin : g_below
                assign main_all_req[g] = main_req[g];
            end else if (g == MAIN_PER_SLOT) begin : g_slot
                assign main_all_req[g] = per_low_req;
            end else begin : g_above
                assign main_all_req[g] = main_req[g-1];
            end
        end
    endgenerate

    assign per_low_req = per_vld && (per_path == PATH_LOW);
    assign per_hi_req  = per_vld && (per_path == PATH_HIGH);

    // The peripheral selection is released by whichever line it ended up on.
    assign per_clr = (crit_vld && clr_crit && (crit_q_idx == CIW'(NUM_DED)))
                   || (main_clr_hit && (main_idx == MIW'(MAIN_PER_SLOT)));

    irq_per_stage #(.NP(NUM_PER), .PW(PW), .IW(PIW)) per_i (
        .clk      (clk),
        .rst      (rst),
        .req      (per_req),
        .pri      (per_pri),
        .route_hi (per_route_hi),
        .allow    (!main_vld),
        .clr      (per_clr),
        .vld      (per_vld),
        .idx      (per_idx),
        .path     (per_path)
    );

    irq_main_stage #(.NM(NUM_MAIN), .PW(PW), .IW(MIW)) main_i (
        .clk      (clk),
        .rst      (rst),
        .req      (main_all_req),
        .pri      (main_pri),
        .clr_mgmt (clr_mgmt),
        .clr_norm (clr_norm),
        .vld      (main_vld),
        .idx      (main_idx),
        .line     (main_line),
        .clr_hit  (main_clr_hit)
    );

    irq_crit_stage #(.ND(NUM_DED), .IW(CIW)) crit_i (
        .clk        (clk),
        .rst        (rst),
        .ded_req    (ded_req),
        .per_hi_req (per_hi_req),
        .clr        (clr_crit),
        .vld        (crit_vld),
        .idx        (crit_q_idx)
    );

    assign irq_crit = crit_vld;
    assign crit_idx = crit_q_idx;
    assign irq_mgmt = main_vld && (main_line == LINE_MGMT);
    assign irq_norm = main_vld && (main_line == LINE_NORM);
    assign mgmt_idx = (main_line == LINE_MGMT) ? main_idx : '0;
    assign norm_idx = (main_line == LINE_NORM) ? main_idx : '0;

    AST_PATH_EXCL: assert property (@(posedge clk) disable iff (rst)
        per_hi_req |-> !(main_vld && (main_idx == MIW'(MAIN_PER_SLOT)))); // R3

    AST_CRIT_SRC: assert property (@(posedge clk) disable iff (rst)
        (crit_vld && (crit_q_idx == CIW'(NUM_DED))) |-> per_hi_req); // R2

    AST_PER_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!per_vld && main_vld) |=> !per_vld); // R7

endmodule

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;

    localparam int NP = 8;
    localparam int NM = 4;
    localparam int ND = 3;
    localparam int PW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   per_req = '0;
    logic [NP*PW-1:0] per_pri = '0;
    logic [NP-1:0]   per_route_hi = '0;
    logic [NM-2:0]   main_req = '0;
    logic [NM*PW-1:0] main_pri = '0;
    logic [ND-1:0]   ded_req = '0;
    logic            clr_crit = 1'b0;
    logic            clr_mgmt = 1'b0;
    logic            clr_norm = 1'b0;
    logic            irq_crit, irq_mgmt, irq_norm, per_vld;
    logic [1:0]      crit_idx, mgmt_idx, norm_idx;
    logic [2:0]      per_idx;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    irq_router dut_i (
        .clk          (clk),
        .rst          (rst),
        .per_req      (per_req),
        .per_pri      (per_pri),
        .per_route_hi (per_route_hi),
        .main_req     (main_req),
        .main_pri     (main_pri),
        .ded_req      (ded_req),
        .clr_crit     (clr_crit),
        .clr_mgmt     (clr_mgmt),
        .clr_norm     (clr_norm),
        .irq_crit     (irq_crit),
        .crit_idx     (crit_idx),
        .irq_mgmt     (irq_mgmt),
        .mgmt_idx     (mgmt_idx),
        .irq_norm     (irq_norm),
        .norm_idx     (norm_idx),
        .per_vld      (per_vld),
        .per_idx      (per_idx)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act %0d exp %0d", cyc, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_defaults();
        for (int i = 0; i < NP; i++) per_pri[i*PW +: PW] = 4'd1;
        for (int j = 0; j < NM; j++) main_pri[j*PW +: PW] = 4'd1;
        per_route_hi = '0;
    endtask

    task automatic drain();
        per_req  = '0;
        main_req = '0;
        ded_req  = '0;
        repeat (4) begin
            clr_crit = 1'b1; clr_mgmt = 1'b1; clr_norm = 1'b1;
            step(1);
        end
        clr_crit = 1'b0; clr_mgmt = 1'b0; clr_norm = 1'b0;
        set_defaults();
        step(1);
    endtask

    task automatic pulse_norm();
        clr_norm = 1'b1; step(1); clr_norm = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 reset crit", irq_crit, 0);
        chk("R10 reset mgmt", irq_mgmt, 0);
        chk("R10 reset norm", irq_norm, 0);
        chk("R10 reset per_vld", per_vld, 0);
    endtask

    task automatic t_per_pick();
        per_pri[2*PW +: PW] = 4'd2;
        per_pri[5*PW +: PW] = 4'd7;
        per_req = 8'b0010_0100;
        step(1);
        chk("R1 per_vld", per_vld, 1);
        chk("R1 per_idx highest prio", per_idx, 5);
        step(1);
        chk("R3 low path norm", irq_norm, 1);
        chk("R4 norm_idx slot", norm_idx, 3);
        chk("R5 no mgmt", irq_mgmt, 0);
        per_req = 8'b0000_0100;
        pulse_norm();
        chk("R9 cleared norm", irq_norm, 0);
        chk("R9 cleared per", per_vld, 0);
        step(1);
        chk("R9 rearbitrate per_idx", per_idx, 2);
        drain();
    endtask

    task automatic t_tie();
        per_pri[1*PW +: PW] = 4'd5;
        per_pri[4*PW +: PW] = 4'd5;
        per_req = 8'b0001_0010;
        step(1);
        chk("R1 tie lowest index", per_idx, 1);
        drain();
    endtask

    task automatic t_route_hi();
        per_route_hi[6] = 1'b1;
        per_req = 8'b0100_0000;
        step(1);
        chk("R2 per latched", per_idx, 6);
        step(1);
        chk("R2 crit raised", irq_crit, 1);
        chk("R2 crit_idx per slot", crit_idx, 3);
        chk("R3 not on low path", irq_norm, 0);
        per_req = '0;
        clr_crit = 1'b1; step(1); clr_crit = 1'b0;
        chk("R9 crit cleared", irq_crit, 0);
        chk("R9 per released", per_vld, 0);
        drain();
    endtask

    task automatic t_holdoff();
        main_req[0] = 1'b1;
        step(1);
        chk("R4 ext main norm", irq_norm, 1);
        chk("R4 norm_idx 0", norm_idx, 0);
        per_route_hi[6] = 1'b1;
        per_req = 8'b0100_0000;
        step(3);
        chk("R7 per held off", per_vld, 0);
        chk("R7 crit held off", irq_crit, 0);
        main_req = '0;
        pulse_norm();
        step(1);
        chk("R7 per after clear", per_vld, 1);
        step(1);
        chk("R7 crit after clear", irq_crit, 1);
        chk("R7 crit_idx", crit_idx, 3);
        drain();
    endtask

    task automatic t_ded();
        main_req[0] = 1'b1;
        step(1);
        ded_req = 3'b110;
        step(1);
        chk("R8 ded not held", irq_crit, 1);
        chk("R8 lowest ded", crit_idx, 1);
        chk("R8 norm still up", irq_norm, 1);
        ded_req = 3'b100;
        clr_crit = 1'b1; step(1); clr_crit = 1'b0;
        chk("R9 crit clear", irq_crit, 0);
        step(1);
        chk("R8 next ded", crit_idx, 2);
        drain();
    endtask

    task automatic t_mgmt_block();
        main_pri[1*PW +: PW] = 4'b1001;
        main_req[0] = 1'b1;
        step(1);
        chk("R5 norm from msb0", irq_norm, 1);
        main_req[1] = 1'b1;
        step(2);
        chk("R6 mgmt blocked", irq_mgmt, 0);
        chk("R6 norm idx kept", norm_idx, 0);
        main_req[0] = 1'b0;
        pulse_norm();
        step(1);
        chk("R5 mgmt raised", irq_mgmt, 1);
        chk("R5 mgmt_idx", mgmt_idx, 1);
        chk("R6 norm low", irq_norm, 0);
        drain();
    endtask

    task automatic t_slot_mgmt();
        main_pri[3*PW +: PW] = 4'b1000;
        per_req = 8'b0000_0001;
        step(2);
        chk("R5 slot msb mgmt", irq_mgmt, 1);
        chk("R5 slot mgmt_idx", mgmt_idx, 3);
        drain();
    endtask

    task automatic t_latch();
        main_req[2] = 1'b1;
        step(1);
        chk("R4 idx2", norm_idx, 2);
        main_req = '0;
        clr_mgmt = 1'b1; step(1); clr_mgmt = 1'b0;
        step(1);
        chk("R9 wrong clear ignored", irq_norm, 1);
        chk("R9 idx kept", norm_idx, 2);
        pulse_norm();
        chk("R9 right clear", irq_norm, 0);
        drain();
    endtask

    task automatic t_midreset();
        main_req[0] = 1'b1;
        ded_req = 3'b001;
        step(1);
        rst = 1'b1;
        step(1);
        chk("R10 reset crit", irq_crit, 0);
        chk("R10 reset norm", irq_norm, 0);
        main_req = '0;
        ded_req = '0;
        rst = 1'b0;
        step(1);
    endtask

    initial begin
        set_defaults();
        step(2);
        t_reset();
        rst = 1'b0;
        step(1);
        t_per_pick();
        t_tie();
        t_route_hi();
        t_holdoff();
        t_ded();
        t_mgmt_block();
        t_slot_mgmt();
        t_latch();
        t_midreset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule